// File: doc/BRIEF.md
# Receive Packet FIFO with Register Read-Out

This block takes 32-bit stream beats from an upstream source, groups them into packets closed by a last-beat marker, and holds them until a host drains them through a small register port. Each finished packet leaves behind a word count in a separate length queue, so the host always knows exactly how much to pull.

The host drains a packet in two steps. First it reads the length register, which hands over the byte size of the oldest finished packet and makes that packet current. Then it reads the data register once per word. An occupancy register tells the host whether anything can be read at all. A status register records when packets finish, when a keyed flush completes, and three separate read-side mistakes: reading a length before the previous packet was drained, reading data past the end of the current packet, and reading data from an empty store. The status bits are write-one-to-clear.

The upstream side is never told to drop anything. The ready signal falls as soon as either the word storage or the length queue is full. Register reads return their value one cycle after the read strobe.

Top module: `rx_packet_fifo`

## Requirements
- R1: While reset is held and right after it, `s_tready` is 1, `reg_rdata` is 0, occupancy reads 0 and every status bit reads 0.
- R2: `s_tready` is 0 exactly when the word store holds 2^WORD_AW words (finished packets plus the open packet) or the length queue holds 2^PKT_AW packets. A beat offered while `s_tready` is 0 is not taken, and no beat is ever lost.
- R3: A read of offset 0x1C returns the number of stored words that belong to finished packets and have not yet been popped or discarded. Beats of a packet whose last beat has not been accepted are not counted. A word committed and a word popped in the same cycle cancel out.
- R4: A read of offset 0x24 returns 4 times the word count of the oldest finished packet and makes that packet current. When no finished packet is queued, the read returns 0.
- R5: Each read of offset 0x20, while the current packet has words left, returns that packet's next word in arrival order and consumes it.
- R6: A read of offset 0x20 with no word left in the current packet returns 0, moves nothing and sets status bit 30. If occupancy is also 0, the same read sets status bit 29.
- R7: A read of offset 0x24 while the current packet still has unread words discards those words and sets status bit 31. The read then proceeds as in R4.
- R8: Accepting a beat with `s_tlast` = 1 sets status bit 26.
- R9: A write to offset 0x18 whose low byte is 0xA5 empties the store, the length queue and the open packet, and sets status bit 23. A beat accepted in the same cycle is discarded. Any other write value to 0x18 changes nothing.
- R10: Status (offset 0x00) uses only bits 31, 30, 29, 26 and 23. A write to 0x00 clears each bit whose write-data bit is 1. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: `reg_rdata` carries the value of a read in the cycle after `reg_rd`, and is 0 in every other cycle. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Stream beat data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Marks the final beat of a packet |
| s_tready | output | 1 | Block can take a beat this cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |

## Verification
Two pairs of events can land in the same clock. The first pair is a packet's last beat being committed while the host pops a word or reads occupancy. The second pair is a status event being set while the host writes a clear to the same bit. The bench provokes both on purpose: it drives the closing beat and the host access at the same falling edge, and it overlaps a stalled long packet with a concurrent drain. A behavioural model built on queues predicts the ready line and the read data for every cycle. Each outcome is judged against that model: the occupancy must reflect both the add and the subtract, and the status bit must survive the clear.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  localparam int REG_W = 32;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_FLUSH  = 8'h18;
  localparam logic [7:0] OFS_OCC    = 8'h1C;
  localparam logic [7:0] OFS_DATA   = 8'h20;
  localparam logic [7:0] OFS_LEN    = 8'h24;

  localparam logic [7:0] FLUSH_KEY = 8'hA5;

  localparam int BIT_UNDERREAD  = 31;
  localparam int BIT_OVERREAD   = 30;
  localparam int BIT_EMPTY_RD   = 29;
  localparam int BIT_PKT_DONE   = 26;
  localparam int BIT_FLUSH_DONE = 23;

  localparam logic [REG_W-1:0] STATUS_MASK =
      (32'd1 << BIT_UNDERREAD) | (32'd1 << BIT_OVERREAD) | (32'd1 << BIT_EMPTY_RD) |
      (32'd1 << BIT_PKT_DONE)  | (32'd1 << BIT_FLUSH_DONE);

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_STATUS,
    ACC_FLUSH,
    ACC_OCC,
    ACC_DATA,
    ACC_LEN
  } acc_e;

  function automatic acc_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_STATUS: decode_ofs = ACC_STATUS;
      OFS_FLUSH:  decode_ofs = ACC_FLUSH;
      OFS_OCC:    decode_ofs = ACC_OCC;
      OFS_DATA:   decode_ofs = ACC_DATA;
      OFS_LEN:    decode_ofs = ACC_LEN;
      default:    decode_ofs = ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rxpf_word_store.sv
module rxpf_word_store #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [AW:0]       adv_i,
  output logic [DATA_W-1:0] head_o,
  output logic [AW:0]       count_o,
  output logic              full_o
);
  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]       cnt_q, cnt_d;

  always_comb begin
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = push_i ? wr_q + AW'(1) : wr_q;
      rd_d  = rd_q + adv_i[AW-1:0];
      cnt_d = cnt_q + {{AW{1'b0}}, push_i} - adv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= push_data_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == FULL_CNT);

  // R2: no word is written into a full store
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R5: the read side never advances past what is stored
  assert_adv_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i <= count_o);

endmodule

// File: rtl/rxpf_len_queue.sv
module rxpf_len_queue #(
  parameter int LW  = 6,
  parameter int QAW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [LW-1:0] push_len_i,
  input  logic          pop_i,
  output logic [LW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int           QDEPTH   = 1 << QAW;
  localparam logic [QAW:0] FULL_CNT = (QAW+1)'(QDEPTH);

  logic [LW-1:0]  slot [QDEPTH];
  logic [QAW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [QAW:0]   cnt_q, cnt_d;

  always_comb begin
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = push_i ? wr_q + QAW'(1) : wr_q;
      rd_d  = pop_i  ? rd_q + QAW'(1) : rd_q;
      cnt_d = cnt_q + {{QAW{1'b0}}, push_i} - {{QAW{1'b0}}, pop_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) slot[wr_q] <= push_len_i;
  end

  assign head_o  = slot[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);

  // R2: no length entry is written into a full queue
  assert_q_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R4: a packet is only made current when one is queued
  assert_q_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/rxpf_status.sv
module rxpf_status
  import rxpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] flags_o
);
  logic [REG_W-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = ((flags_q & ~clr_i) | set_i) & STATUS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R10: an event raised in a cycle always shows in the next, clear or not
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/rx_packet_fifo.sv
module rx_packet_fifo
  import rxpf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 5,
  parameter int PKT_AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int CW       = WORD_AW + 1;
  localparam int BYTE_SH  = $clog2(DATA_W / 8);

  acc_e             rd_kind, wr_kind;
  logic             store_full, q_full, q_empty;
  logic             beat, commit, flush;
  logic             rd_data, rd_len, pop_word, take_pkt;
  logic [CW-1:0]    adv, store_cnt, q_head;
  logic [DATA_W-1:0] head_word;
  logic [CW-1:0]    open_q, open_d, remain_q, remain_d, comp_q, comp_d;
  logic [REG_W-1:0] rdata_q, rdata_d, set_vec, clr_vec, flags;

  // access decode
  assign rd_kind = reg_rd ? decode_ofs(reg_addr) : ACC_NONE;
  assign wr_kind = reg_wr ? decode_ofs(reg_addr) : ACC_NONE;

  assign s_tready = !store_full && !q_full;
  assign beat     = s_tvalid && s_tready;
  assign commit   = beat && s_tlast;
  assign flush    = (wr_kind == ACC_FLUSH) && (reg_wdata[7:0] == FLUSH_KEY);
  assign rd_data  = (rd_kind == ACC_DATA);
  assign rd_len   = (rd_kind == ACC_LEN);
  assign pop_word = rd_data && (remain_q != '0);
  assign take_pkt = rd_len && !q_empty;
  assign adv      = pop_word ? CW'(1) : (rd_len ? remain_q : '0);

  rxpf_word_store #(.DATA_W(DATA_W), .AW(WORD_AW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .push_i      (beat),
    .push_data_i (s_tdata),
    .adv_i       (adv),
    .head_o      (head_word),
    .count_o     (store_cnt),
    .full_o      (store_full)
  );

  rxpf_len_queue #(.LW(CW), .QAW(PKT_AW)) u_lenq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .push_i     (commit),
    .push_len_i (open_q + CW'(1)),
    .pop_i      (take_pkt),
    .head_o     (q_head),
    .empty_o    (q_empty),
    .full_o     (q_full)
  );

  // packet bookkeeping next state
  always_comb begin
    if (flush) begin
      open_d   = '0;
      remain_d = '0;
      comp_d   = '0;
    end else begin
      open_d   = commit ? '0 : (beat ? open_q + CW'(1) : open_q);
      if (rd_len)        remain_d = take_pkt ? q_head : '0;
      else if (pop_word) remain_d = remain_q - CW'(1);
      else               remain_d = remain_q;
      comp_d   = comp_q + (commit ? open_q + CW'(1) : '0) - adv;
    end
  end

  // status events and clears
  always_comb begin
    set_vec = '0;
    set_vec[BIT_UNDERREAD]  = rd_len && (remain_q != '0);
    set_vec[BIT_OVERREAD]   = rd_data && (remain_q == '0);
    set_vec[BIT_EMPTY_RD]   = rd_data && (remain_q == '0) && (comp_q == '0);
    set_vec[BIT_PKT_DONE]   = commit;
    set_vec[BIT_FLUSH_DONE] = flush;
    clr_vec = (wr_kind == ACC_STATUS) ? reg_wdata : '0;
  end

  rxpf_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  // read data mux
  always_comb begin
    rdata_d = '0;
    case (rd_kind)
      ACC_STATUS: rdata_d = flags;
      ACC_OCC:    rdata_d = REG_W'(comp_q);
      ACC_DATA:   if (pop_word) rdata_d = REG_W'(head_word);
      ACC_LEN:    if (take_pkt) rdata_d = REG_W'(q_head) << BYTE_SH;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= '0;
      remain_q <= '0;
      comp_q   <= '0;
      rdata_q  <= '0;
    end else begin
      open_q   <= open_d;
      remain_q <= remain_d;
      comp_q   <= comp_d;
      rdata_q  <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  // R3: nothing readable means no queued packet and no current words
  assert_occ_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_q == '0) |-> (q_empty && remain_q == '0));
  // R3: finished words never exceed what the store holds
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    comp_q <= store_cnt);
  // R4: a length read hands back the byte count of the queued head
  assert_len_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_pkt |=> (reg_rdata == (REG_W'($past(q_head)) << BYTE_SH)));
  // R6: data read past the packet end returns zero and flags it
  assert_overread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && remain_q == '0) |=> (reg_rdata == '0 && flags[BIT_OVERREAD]));
  // R8: a closing beat raises the completion flag
  assert_commit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> flags[BIT_PKT_DONE]);
  // R9: a keyed flush empties everything and reopens the stream
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (comp_q == '0 && q_empty && s_tready && flags[BIT_FLUSH_DONE]));
  // R11: read data is zero in a cycle after no read
  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));

endmodule

// File: tb/sim_rx_packet_fifo.sv
module sim_rx_packet_fifo;
  localparam int DATA_W  = 32;
  localparam int WORD_AW = 5;
  localparam int PKT_AW  = 2;
  localparam int DEPTH   = 1 << WORD_AW;
  localparam int PKTS    = 1 << PKT_AW;

  localparam logic [7:0] A_STATUS = 8'h00;
  localparam logic [7:0] A_FLUSH  = 8'h18;
  localparam logic [7:0] A_OCC    = 8'h1C;
  localparam logic [7:0] A_DATA   = 8'h20;
  localparam logic [7:0] A_LEN    = 8'h24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] s_tdata = '0;
  logic              s_tvalid = 1'b0;
  logic              s_tlast = 1'b0;
  logic              s_tready;
  logic              reg_rd = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    started = 1'b0;
  string phase_tag = "";

  always #5 clk = ~clk;

  rx_packet_fifo #(.DATA_W(DATA_W), .WORD_AW(WORD_AW), .PKT_AW(PKT_AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tdata   (s_tdata),
    .s_tvalid  (s_tvalid),
    .s_tlast   (s_tlast),
    .s_tready  (s_tready),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_done[$];   // words of finished packets, oldest first
  logic [31:0] m_open[$];   // words of the packet still arriving
  int          m_lens[$];   // word counts of queued packets
  int          m_remain = 0;
  logic [31:0] m_status = '0;
  logic [31:0] exp_rdata = '0;
  string       exp_tag = "R1";

  function automatic bit m_ready();
    return ((m_done.size() + m_open.size()) < DEPTH) && (m_lens.size() < PKTS);
  endfunction

  always @(posedge clk) begin
    bit          acc;
    bit          flush;
    logic [31:0] setv;
    logic [31:0] rv;
    string       tg;
    started = 1'b1;
    if (!rst_n) begin
      m_done.delete(); m_open.delete(); m_lens.delete();
      m_remain = 0; m_status = '0; exp_rdata = '0; exp_tag = "R1";
    end else begin
      acc   = s_tvalid && m_ready();
      flush = reg_wr && reg_addr == A_FLUSH && reg_wdata[7:0] == 8'hA5;
      setv  = '0;
      rv    = '0;
      tg    = "R11";
      if (reg_rd) begin
        case (reg_addr)
          A_STATUS: begin rv = m_status; tg = "R10"; end
          A_OCC:    begin rv = 32'(m_done.size()); tg = "R3"; end
          A_LEN: begin
            tg = "R4";
            if (m_remain > 0) begin
              setv[31] = 1'b1; tg = "R7";
              for (int k = 0; k < m_remain; k++) void'(m_done.pop_front());
            end
            if (m_lens.size() > 0) begin
              m_remain = m_lens.pop_front();
              rv = 32'(m_remain * 4);
            end else m_remain = 0;
          end
          A_DATA: begin
            tg = "R5";
            if (m_remain > 0) begin
              rv = m_done.pop_front();
              m_remain--;
            end else begin
              tg = "R6";
              setv[30] = 1'b1;
              if (m_done.size() == 0) setv[29] = 1'b1;
            end
          end
          default: tg = "R11";
        endcase
      end
      if (acc) begin
        m_open.push_back(s_tdata);
        if (s_tlast) begin
          foreach (m_open[k]) m_done.push_back(m_open[k]);
          m_lens.push_back(m_open.size());
          m_open.delete();
          setv[26] = 1'b1;
        end
      end
      if (flush) begin
        m_done.delete(); m_open.delete(); m_lens.delete();
        m_remain = 0;
        setv[23] = 1'b1;
      end
      if (reg_wr && reg_addr == A_STATUS) m_status = m_status & ~reg_wdata;
      m_status  = m_status | setv;
      exp_rdata = rv;
      exp_tag   = (phase_tag != "" && reg_rd) ? phase_tag : tg;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(reg_rdata === exp_rdata, exp_tag, reg_rdata, exp_rdata);
      chk(s_tready === m_ready(), "R2", {31'd0, s_tready}, {31'd0, m_ready()});
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  function automatic logic [31:0] wv(input int p, input int i);
    return 32'hC000_0000 + 32'(p * 256 + i);
  endfunction

  task automatic send_beat(input logic [31:0] d, input bit last);
    bit ok;
    s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
    forever begin
      ok = s_tready;
      @(negedge clk);
      if (ok) break;
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic send_pkt(input int p, input int n);
    for (int i = 0; i < n; i++) send_beat(wv(p, i), i == n - 1);
  endtask

  task automatic host_rd(input logic [7:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                        // R1 reset state compared above
    @(negedge clk);
    host_rd(A_OCC);                      // R1 occupancy zero after reset
    host_rd(A_STATUS);                   // R1 status zero after reset

    // R3 R4 R5: three queued packets, open packet hidden from occupancy
    send_pkt(0, 3);
    send_pkt(1, 1);
    send_beat(wv(2, 0), 1'b0);
    send_beat(wv(2, 1), 1'b0);
    host_rd(A_OCC);
    for (int i = 2; i < 5; i++) send_beat(wv(2, i), i == 4);
    host_rd(A_OCC);
    host_rd(A_LEN);
    repeat (3) host_rd(A_DATA);
    host_rd(A_LEN);
    host_rd(A_DATA);
    host_rd(A_LEN);
    repeat (5) host_rd(A_DATA);

    // R8 then R10 clear
    phase_tag = "R8";
    host_rd(A_STATUS);
    phase_tag = "R10";
    host_wr(A_STATUS, 32'hFFFF_FFFF);
    host_rd(A_STATUS);

    // R6: read too many words, first on an empty store, then with a packet pending
    phase_tag = "R6";
    host_rd(A_DATA);
    host_rd(A_STATUS);
    host_wr(A_STATUS, 32'hFFFF_FFFF);
    send_pkt(3, 2);
    host_rd(A_DATA);
    host_rd(A_OCC);
    host_rd(A_STATUS);
    host_wr(A_STATUS, 32'hFFFF_FFFF);

    // R7: length read before the current packet is drained
    phase_tag = "R7";
    send_pkt(4, 3);
    host_rd(A_LEN);
    host_rd(A_DATA);
    host_rd(A_LEN);
    host_rd(A_DATA);
    host_rd(A_OCC);
    host_rd(A_STATUS);
    host_wr(A_STATUS, 32'hFFFF_FFFF);

    // R2: length queue full, beat held off
    phase_tag = "R2";
    for (int p = 0; p < PKTS; p++) send_pkt(10 + p, 1);
    s_tvalid = 1'b1; s_tdata = 32'hDEAD_BEEF; s_tlast = 1'b1;
    repeat (5) @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    host_rd(A_OCC);

    // R9: wrong key ignored, right key flushes, open packet discarded
    phase_tag = "R9";
    host_wr(A_FLUSH, 32'h0000_005A);
    host_rd(A_OCC);
    host_wr(A_FLUSH, 32'h0000_00A5);
    host_rd(A_OCC);
    host_rd(A_LEN);
    host_rd(A_STATUS);
    host_wr(A_STATUS, 32'hFFFF_FFFF);
    send_beat(wv(20, 0), 1'b0);
    send_beat(wv(20, 1), 1'b0);
    host_wr(A_FLUSH, 32'h0000_00A5);
    send_beat(wv(21, 0), 1'b1);
    host_rd(A_LEN);
    host_rd(A_DATA);
    host_wr(A_STATUS, 32'hFFFF_FFFF);

    // R2: word store full, stalled packet resumes while the host drains
    phase_tag = "R2";
    send_pkt(30, 20);
    fork
      send_pkt(31, 20);
      begin
        repeat (40) @(negedge clk);
        host_rd(A_OCC);
        host_rd(A_LEN);
        repeat (20) host_rd(A_DATA);
      end
    join
    host_rd(A_LEN);
    repeat (20) host_rd(A_DATA);

    // R10: clear and completion in one cycle; R3: commit and pop in one cycle
    phase_tag = "R10";
    host_wr(A_STATUS, 32'hFFFF_FFFF);
    send_pkt(40, 3);
    host_rd(A_LEN);
    send_beat(wv(41, 0), 1'b0);
    s_tvalid = 1'b1; s_tdata = wv(41, 1); s_tlast = 1'b1;
    reg_wr = 1'b1; reg_addr = A_STATUS; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; reg_wr = 1'b0;
    host_rd(A_STATUS);
    phase_tag = "R3";
    send_beat(wv(42, 0), 1'b0);
    s_tvalid = 1'b1; s_tdata = wv(42, 1); s_tlast = 1'b1;
    reg_rd = 1'b1; reg_addr = A_DATA;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; reg_rd = 1'b0;
    host_rd(A_OCC);
    repeat (2) host_rd(A_DATA);
    host_rd(A_LEN);
    repeat (2) host_rd(A_DATA);
    host_rd(A_LEN);
    repeat (2) host_rd(A_DATA);
    host_rd(A_OCC);

    // R11: unmapped offsets read zero, idle cycles read zero
    phase_tag = "R11";
    host_rd(8'h04);
    host_rd(8'h30);
    repeat (3) @(negedge clk);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule